// File: doc/BRIEF.md
# Dual-Phase Trigger and Region-Request Decoder

This block sits behind the deserialiser of a front-end readout chip. It decodes two 80 Mbit/s command lines, each delivered as a pair of bits per bunch-crossing (BC) clock cycle. On the trigger line, the first half-period bit is the early trigger. This trigger has a fixed latency and becomes a single-cycle strobe. The second half-period bit carries the later readout trigger. That trigger has no fixed latency, and after it the same phase carries the serial event identifier of the event it requests. The block gathers the identifier and reports it together with a strobe.

On the region-request line, the block finds short packets that ask one module to read out early. Each packet carries a start header, a type marker, a module address, an event identifier and a trailer. The module address is compared with a strap value on the board. Only a matching packet produces a strobe and an identifier. A packet with a corrupted trailer produces an error strobe and no strobe. All outputs are registered and live in the BC clock domain.

Top module: `trig_cmd_decoder`

## Requirements
- R1: After a synchronous reset, `l0_strobe`, `l1_strobe`, `r3_strobe` and `r3_err` are low, and `l1_l0id` and `r3_l0id` are zero.
- R2: `l0_strobe` is high for exactly the cycle after each clock edge at which `trig_pair[0]` was high. It is low after every edge at which that bit was low, whatever the other phase or the request line carry.
- R3: A high `trig_pair[1]` at an edge while no identifier is being collected starts a readout command. The next 8 edges take `trig_pair[1]` as the identifier, most significant bit first. After the 8th of those edges, `l1_strobe` is high for one cycle and `l1_l0id` holds the identifier. `l1_l0id` changes at no other time.
- R4: While an identifier is being collected, a high `trig_pair[1]` is identifier data and never starts a new command. A new command is accepted at the edge right after the 8th identifier bit.
- R5: A request packet starts when `req_pair` equals 2'b11 at an edge while no packet is in progress. The 8 following edges each deliver two packet bits, `req_pair[1]` first. In arrival order the 16 bits are: type (2 bits), address (4 bits, MSB first), identifier (8 bits, MSB first), trailer (2 bits).
- R6: A packet with type 2'b01, trailer 2'b00 and an address equal to `mod_addr` makes `r3_strobe` high for one cycle after its last edge, with `r3_l0id` equal to its identifier. `r3_l0id` changes at no other time.
- R7: A packet whose address differs from `mod_addr` raises neither strobe, and it leaves `r3_l0id` unchanged.
- R8: A packet whose trailer is not 2'b00 raises `r3_err` for one cycle after its last edge, whatever its address and type, and it does not raise `r3_strobe`.
- R9: A packet with a good trailer and a type other than 2'b01 raises neither `r3_strobe` nor `r3_err`.
- R10: Pairs of 2'b11 inside a packet are packet data. A new packet may start at the edge right after the last pair of the previous one.
- R11: The trigger line and the request line are decoded independently, and activity on one does not change the result of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | BC clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pair | input | 2 | Trigger line bits for this BC: [0] early-trigger phase, [1] readout-trigger phase |
| req_pair | input | 2 | Request line bits for this BC, [1] earlier in time |
| mod_addr | input | 4 | Module address strap |
| l0_strobe | output | 1 | Early trigger strobe |
| l1_strobe | output | 1 | Readout command complete |
| l1_l0id | output | 8 | Identifier of the last readout command |
| r3_strobe | output | 1 | Matching region request received |
| r3_l0id | output | 8 | Identifier of the last matching request |
| r3_err | output | 1 | Request packet with a bad trailer |

## Verification
The hardest case to reach is an identifier or packet body full of ones. A careless decoder would take those bits as fresh commands or headers. The next frame must also start on the very edge after the previous one ends. The bench sends every one of the 256 readout identifiers back to back, with no idle gap, which includes 0xFF. At the same time it sweeps request packets over every address, every bad trailer and every wrong type, also with no gaps. Early-trigger bits are driven from an arithmetic pattern during all of this, so that both phases and both lines are active together.

// File: rtl/trig_cmd_pkg.sv
package trig_cmd_pkg;
  localparam logic [1:0] REQ_HEADER  = 2'b11;
  localparam logic [1:0] REQ_TYPE_OK = 2'b01;
  localparam logic [1:0] REQ_TAIL_OK = 2'b00;
endpackage

// File: rtl/l0l1_decoder.sv
module l0l1_decoder #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            early_bit,
  input  logic            late_bit,
  output logic            l0_strobe,
  output logic            l1_strobe,
  output logic [ID_W-1:0] l1_id
);
  localparam int CW = $clog2(ID_W + 1);

  logic [CW-1:0]   left;
  logic [ID_W-1:0] shreg;
  logic [ID_W-1:0] shnext;

  assign shnext = {shreg[ID_W-2:0], late_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      l0_strobe <= 1'b0;
      l1_strobe <= 1'b0;
      l1_id     <= '0;
      left      <= '0;
      shreg     <= '0;
    end else begin
      l0_strobe <= early_bit;
      l1_strobe <= 1'b0;
      if (left == '0) begin
        if (late_bit) left <= CW'(ID_W);
      end else begin
        shreg <= shnext;
        left  <= left - 1'b1;
        if (left == CW'(1)) begin
          l1_strobe <= 1'b1;
          l1_id     <= shnext;
        end
      end
    end
  end
endmodule

// File: rtl/r3_decoder.sv
module r3_decoder
  import trig_cmd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pair,
  input  logic [ADDR_W-1:0] my_addr,
  output logic              hit,
  output logic [ID_W-1:0]   hit_id,
  output logic              bad
);
  localparam int BODY_W = 2 + ADDR_W + ID_W + 2;
  localparam int PAIRS  = BODY_W / 2;
  localparam int CW     = $clog2(PAIRS + 1);

  logic [CW-1:0]     left;
  logic [BODY_W-1:0] body;
  logic [BODY_W-1:0] full;
  logic [1:0]        f_type;
  logic [1:0]        f_tail;
  logic [ADDR_W-1:0] f_addr;
  logic [ID_W-1:0]   f_id;

  assign full   = {body[BODY_W-3:0], pair};
  assign f_type = full[BODY_W-1 -: 2];
  assign f_addr = full[BODY_W-3 -: ADDR_W];
  assign f_id   = full[ID_W+1:2];
  assign f_tail = full[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      left   <= '0;
      body   <= '0;
      hit    <= 1'b0;
      hit_id <= '0;
      bad    <= 1'b0;
    end else begin
      hit <= 1'b0;
      bad <= 1'b0;
      if (left == '0) begin
        if (pair == REQ_HEADER) left <= CW'(PAIRS);
      end else begin
        body <= full;
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          if (f_tail != REQ_TAIL_OK) begin
            bad <= 1'b1;
          end else if (f_type == REQ_TYPE_OK && f_addr == my_addr) begin
            hit    <= 1'b1;
            hit_id <= f_id;
          end
        end
      end
    end
  end
endmodule

// File: rtl/trig_cmd_decoder.sv
module trig_cmd_decoder #(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        trig_pair,
  input  logic [1:0]        req_pair,
  input  logic [ADDR_W-1:0] mod_addr,
  output logic              l0_strobe,
  output logic              l1_strobe,
  output logic [ID_W-1:0]   l1_l0id,
  output logic              r3_strobe,
  output logic [ID_W-1:0]   r3_l0id,
  output logic              r3_err
);
  l0l1_decoder #(.ID_W(ID_W)) u_trig (
    .clk(clk), .rst(rst),
    .early_bit(trig_pair[0]), .late_bit(trig_pair[1]),
    .l0_strobe(l0_strobe), .l1_strobe(l1_strobe), .l1_id(l1_l0id)
  );

  r3_decoder #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_req (
    .clk(clk), .rst(rst), .pair(req_pair), .my_addr(mod_addr),
    .hit(r3_strobe), .hit_id(r3_l0id), .bad(r3_err)
  );
endmodule

// File: rtl/trig_cmd_decoder_chk.sv
module trig_cmd_decoder_chk #(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        trig_pair,
  input logic [1:0]        req_pair,
  input logic [ADDR_W-1:0] mod_addr,
  input logic              l0_strobe,
  input logic              l1_strobe,
  input logic [ID_W-1:0]   l1_l0id,
  input logic              r3_strobe,
  input logic [ID_W-1:0]   r3_l0id,
  input logic              r3_err
);
  localparam int PAIRS = (2 + ADDR_W + ID_W + 2) / 2;

  logic [7:0] l1_gap;
  logic [7:0] r3_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      l1_gap <= 8'hFF;
      r3_gap <= 8'hFF;
    end else begin
      if (l1_strobe) l1_gap <= 8'd1;
      else if (l1_gap != 8'hFF) l1_gap <= l1_gap + 8'd1;
      if (r3_strobe || r3_err) r3_gap <= 8'd1;
      else if (r3_gap != 8'hFF) r3_gap <= r3_gap + 8'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!l0_strobe && !l1_strobe && !r3_strobe && !r3_err && l1_l0id == '0 && r3_l0id == '0)); // R1
  AST_L0_ECHO: assert property (@(posedge clk) disable iff (rst) trig_pair[0] |=> l0_strobe); // R2
  AST_L0_SILENT: assert property (@(posedge clk) disable iff (rst) !trig_pair[0] |=> !l0_strobe); // R2
  AST_L1_ID_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(l1_l0id) |-> l1_strobe); // R3
  AST_L1_SPACING: assert property (@(posedge clk) disable iff (rst) l1_strobe |-> (l1_gap >= 8'(ID_W + 1))); // R4
  AST_R3_ID_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(r3_l0id) |-> r3_strobe); // R6
  AST_R3_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(r3_strobe && r3_err)); // R8
  AST_R3_SPACING: assert property (@(posedge clk) disable iff (rst) (r3_strobe || r3_err) |-> (r3_gap >= 8'(PAIRS + 1))); // R10
endmodule

bind trig_cmd_decoder trig_cmd_decoder_chk #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .trig_pair(trig_pair), .req_pair(req_pair),
  .mod_addr(mod_addr), .l0_strobe(l0_strobe), .l1_strobe(l1_strobe),
  .l1_l0id(l1_l0id), .r3_strobe(r3_strobe), .r3_l0id(r3_l0id), .r3_err(r3_err)
);

// File: tb/trig_cmd_decoder_tb.sv
module trig_cmd_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] trig_pair = 2'b00;
  logic [1:0] req_pair = 2'b00;
  logic [3:0] mod_addr = 4'h6;
  logic       l0_strobe, l1_strobe, r3_strobe, r3_err;
  logic [7:0] l1_l0id, r3_l0id;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] last_l1 = 8'h00;
  logic [7:0] last_r3 = 8'h00;

  always #5 clk = ~clk;

  trig_cmd_decoder u_dut (
    .clk(clk), .rst(rst), .trig_pair(trig_pair), .req_pair(req_pair),
    .mod_addr(mod_addr), .l0_strobe(l0_strobe), .l1_strobe(l1_strobe),
    .l1_l0id(l1_l0id), .r3_strobe(r3_strobe), .r3_l0id(r3_l0id), .r3_err(r3_err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Nine BC cycles: one start cycle plus eight body cycles on each line.
  task automatic frame(input logic [8:0] l0bits, input logic l1_go, input logic [7:0] l1id,
                       input logic r3_go, input logic [1:0] ty, input logic [3:0] ad,
                       input logic [7:0] id, input logic [1:0] tr);
    logic [17:0] pkt;
    logic ok, er;
    pkt = {2'b11, ty, ad, id, tr};
    ok = r3_go && ty == 2'b01 && tr == 2'b00 && ad == mod_addr;
    er = r3_go && tr != 2'b00;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      trig_pair[0] = l0bits[i];
      trig_pair[1] = (i == 0) ? l1_go : (l1_go & l1id[8-i]);
      req_pair = r3_go ? pkt[17-2*i -: 2] : 2'b00;
      @(posedge clk);
      #1;
      chk("R2 l0_strobe", {7'd0, l0_strobe}, {7'd0, l0bits[i]});
      if (i < 8) begin
        chk("R4 l1_strobe mid-frame", {7'd0, l1_strobe}, 8'd0);
        chk("R10 r3 strobes mid-packet", {6'd0, r3_strobe, r3_err}, 8'd0);
      end else begin
        chk("R3 l1_strobe", {7'd0, l1_strobe}, {7'd0, l1_go});
        if (l1_go) last_l1 = l1id;
        chk("R3 l1_l0id", l1_l0id, last_l1);
        chk("R6/R7/R9 r3_strobe", {7'd0, r3_strobe}, {7'd0, ok});
        chk("R8 r3_err", {7'd0, r3_err}, {7'd0, er});
        if (ok) last_r3 = id;
        chk("R6/R7 r3_l0id", r3_l0id, last_r3);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    trig_pair = 2'b11;
    req_pair = 2'b11;
    @(posedge clk);
    #1;
    chk("R1 strobes in reset", {4'd0, l0_strobe, l1_strobe, r3_strobe, r3_err}, 8'd0);
    chk("R1 l1_l0id in reset", l1_l0id, 8'd0);
    chk("R1 r3_l0id in reset", r3_l0id, 8'd0);
    @(negedge clk);
    trig_pair = 2'b00;
    req_pair = 2'b00;
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 idle after reset", {4'd0, l0_strobe, l1_strobe, r3_strobe, r3_err}, 8'd0);

    // R3 R4 R11: every identifier back to back, request sweep alongside
    for (int k = 0; k < 256; k++) begin
      logic [8:0] pat;
      logic [7:0] kk;
      kk = 8'(k);
      pat = 9'((k * 37 + 11) ^ (k << 3));
      frame(pat, 1'b1, kk, (k % 3) != 2, 2'b01, kk[3:0], 8'(255 - k), 2'b00);
    end

    // R7: address sweep under a second strap value
    mod_addr = 4'h9;
    for (int a = 0; a < 16; a++)
      frame(9'(a * 73), 1'b0, 8'h00, 1'b1, 2'b01, 4'(a), 8'(a * 17 + 3), 2'b00);

    // R8: bad trailers, matching and mismatching address, any type
    for (int t = 1; t < 4; t++) begin
      frame(9'h0, 1'b0, 8'h00, 1'b1, 2'b01, 4'h9, 8'hC3, 2'(t));
      frame(9'h1FF, 1'b0, 8'h00, 1'b1, 2'(t), 4'h2, 8'h3C, 2'(t));
    end

    // R9: wrong type with good trailer and matching address
    for (int t = 0; t < 4; t++)
      if (t != 1) frame(9'h155, 1'b1, 8'hFF, 1'b1, 2'(t), 4'h9, 8'hFF, 2'b00);

    // R10: packet body of all ones, then another packet at once
    frame(9'h0, 1'b0, 8'h00, 1'b1, 2'b01, 4'h9, 8'hFF, 2'b00);
    frame(9'h0, 1'b0, 8'h00, 1'b1, 2'b01, 4'h9, 8'h5A, 2'b00);
    // R5 R6 R11: request alone, trigger alone
    frame(9'h0, 1'b0, 8'h00, 1'b1, 2'b01, 4'h9, 8'h81, 2'b00);
    frame(9'h0AA, 1'b1, 8'h81, 1'b0, 2'b01, 4'h9, 8'h00, 2'b00);

    @(negedge clk);
    trig_pair = 2'b00;
    req_pair = 2'b00;
    @(posedge clk);
    #1;
    chk("R2 quiet after traffic", {7'd0, l0_strobe}, 8'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule